// File: doc/BRIEF.md
# VBI Line Window Flag Generator

This block follows the scan line of an interlaced video stream and marks each line with two flags. One flag says the line may carry vertical-blanking-interval data. The other says the line is always blanked. A line-start strobe advances the line counter. A field-start strobe that carries a field identifier of zero returns the counter to line 1. A two-bit mode input chooses between 625-line timing and 525-line timing.

In each field the window of lines that may carry VBI data opens at a fixed first line. It closes at a last line that software can program, with one register for each field. The forced-blank ranges have fixed positions for each standard. A forced-blank line is never reported as eligible. The chosen standard is sampled only on a field-start strobe, so a new mode never takes effect partway through a field.

Top module: `vbi_line_flags`

## Requirements
- R1: After reset the line number is 1, the standard is 625-line, the field-1 last line is 22 and the field-2 last line is 335.
- R2: On a cycle where `field_stb` is high and `field_id` is 0, the line number becomes 1 on the next cycle. This takes priority over `line_stb`.
- R3: In every other case `line_stb` raises the line number by one on the next cycle. From the frame's last line (625, or 525 in 525-line timing), or from any higher value, it goes to 1 instead.
- R4: In 625-line timing, `blank_force` is high on lines 1 to 5, on lines 311 to 317 and on lines 623 to 625, and low on every other line.
- R5: In 525-line timing, `blank_force` is high on lines 1 to 6, on lines 261 to 268 and on lines 523 to 525, and low on every other line.
- R6: In 625-line timing, `vbi_ok` is high on a line that is not force-blanked and lies in 6 to `last_f1`, or in 318 to `last_f2`, both ends included.
- R7: In 525-line timing, `vbi_ok` follows the same rule with first lines 7 and 269.
- R8: `vbi_ok` is low on every force-blanked line, even when that line lies inside a programmed window.
- R9: When `cfg_we` is high, `cfg_val` is written on the next cycle to `last_f2` if `cfg_fld` is 1, or to `last_f1` if `cfg_fld` is 0.
- R10: `mode_sel` bit 1 selects the standard: 1 means 525-line and 0 means 625-line. Bit 0 has no effect. The new value is taken only on a cycle where `field_stb` is high, whatever the field identifier. The wrap on that same cycle still uses the previous standard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse at each line start |
| field_stb | input | 1 | One-cycle pulse at each field start |
| field_id | input | 1 | Field being started: 0 is field 1, 1 is field 2 |
| mode_sel | input | 2 | Requested standard; bit 1 set selects 525-line |
| cfg_we | input | 1 | Write strobe for a last-line register |
| cfg_fld | input | 1 | Register written: 0 is field 1, 1 is field 2 |
| cfg_val | input | LW | Value written |
| line_num | output | LW | Current line number |
| vbi_ok | output | 1 | Line may carry VBI data |
| blank_force | output | 1 | Line is always blanked |
| last_f1 | output | LW | Last VBI line of field 1 |
| last_f2 | output | LW | Last VBI line of field 2 |

## Verification
A directed walk through a whole 625-line frame, and later a whole 525-line frame, checks every line boundary of each standard. Over this walk the field-1 window is programmed to run into the field-2 blanked range, so the overlap shows whether blanking takes priority over eligibility. A mode request made without a field strobe is probed on line 6, which is eligible in one standard and blanked in the other. This shows whether the mode is sampled too early. A random phase then mixes line strobes, field strobes of both identities, register writes and mode requests, and compares every output with a bench model. This covers simultaneous strobes and wraps from out-of-range lines.

// File: rtl/vbi_line_flags.sv
module vbi_line_flags #(
  parameter int LW = 10,
  parameter int DEF_LAST_F1 = 22,
  parameter int DEF_LAST_F2 = 335
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_stb,
  input  logic          field_stb,
  input  logic          field_id,
  input  logic [1:0]    mode_sel,
  input  logic          cfg_we,
  input  logic          cfg_fld,
  input  logic [LW-1:0] cfg_val,
  output logic [LW-1:0] line_num,
  output logic          vbi_ok,
  output logic          blank_force,
  output logic [LW-1:0] last_f1,
  output logic [LW-1:0] last_f2
);

  logic          m525_q;
  logic [LW-1:0] line_q, last1_q, last2_q;
  logic [LW-1:0] total, first1, first2;
  logic          b625, b525, win;

  assign total  = m525_q ? LW'(525) : LW'(625);
  assign first1 = m525_q ? LW'(7)   : LW'(6);
  assign first2 = m525_q ? LW'(269) : LW'(318);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m525_q  <= 1'b0;
      line_q  <= LW'(1);
      last1_q <= LW'(DEF_LAST_F1);
      last2_q <= LW'(DEF_LAST_F2);
    end else begin
      if (field_stb) m525_q <= mode_sel[1];
      if (field_stb && !field_id) line_q <= LW'(1);
      else if (line_stb) line_q <= (line_q >= total) ? LW'(1) : line_q + LW'(1);
      if (cfg_we && cfg_fld)  last2_q <= cfg_val;
      if (cfg_we && !cfg_fld) last1_q <= cfg_val;
    end
  end

  assign b625 = (line_q >= LW'(623)) || (line_q <= LW'(5)) ||
                (line_q >= LW'(311) && line_q <= LW'(317));
  assign b525 = (line_q >= LW'(523)) || (line_q <= LW'(6)) ||
                (line_q >= LW'(261) && line_q <= LW'(268));
  assign win  = (line_q >= first1 && line_q <= last1_q) ||
                (line_q >= first2 && line_q <= last2_q);

  assign blank_force = m525_q ? b525 : b625;
  assign vbi_ok      = win && !blank_force;
  assign line_num    = line_q;
  assign last_f1     = last1_q;
  assign last_f2     = last2_q;

  assert_field1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (field_stb && !field_id) |=> (line_num == LW'(1)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !field_stb && line_q < total) |=> (line_num == $past(line_num) + LW'(1)));

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num >= LW'(1)) && (line_num <= LW'(625)));

  assert_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_fld) |=> (last_f1 == $past(cfg_val)));

  assert_modehold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !field_stb |=> (m525_q == $past(m525_q)));

endmodule

// File: tb/vbi_line_flags_tb.sv
`timescale 1ns/1ps
module vbi_line_flags_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic line_stb = 0, field_stb = 0, field_id = 0, cfg_we = 0, cfg_fld = 0;
  logic [1:0] mode_sel = 2'b00;
  logic [9:0] cfg_val = '0;
  logic [9:0] line_num, last_f1, last_f2;
  logic vbi_ok, blank_force;

  int checks = 0, errors = 0;
  bit done = 0;
  int e_line = 1, e_l1 = 22, e_l2 = 335;
  bit e_m525 = 0;

  always #2 clk = ~clk;

  vbi_line_flags u_dut (.clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
    .field_id(field_id), .mode_sel(mode_sel), .cfg_we(cfg_we), .cfg_fld(cfg_fld),
    .cfg_val(cfg_val), .line_num(line_num), .vbi_ok(vbi_ok), .blank_force(blank_force),
    .last_f1(last_f1), .last_f2(last_f2));

  function automatic bit f_blank(int l, bit m);
    if (m) return (l >= 523) || (l <= 6) || (l >= 261 && l <= 268);
    return (l >= 623) || (l <= 5) || (l >= 311 && l <= 317);
  endfunction

  function automatic bit f_win(int l, bit m, int a, int b);
    return (l >= (m ? 7 : 6) && l <= a) || (l >= (m ? 269 : 318) && l <= b);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (line %0d)", tag, act, exp, e_line);
    end
  endtask

  task automatic check_all(bit f1start);
    bit bl = f_blank(e_line, e_m525);
    bit wn = f_win(e_line, e_m525, e_l1, e_l2);
    chk(f1start ? "R2 line" : "R3 line", int'(line_num), e_line);
    chk(e_m525 ? "R5 blank" : "R4 blank", int'(blank_force), int'(bl));
    chk((bl && wn) ? "R8 eligible" : (e_m525 ? "R7 eligible" : "R6 eligible"),
        int'(vbi_ok), int'(wn && !bl));
    chk("R9 last1", int'(last_f1), e_l1);
    chk("R9 last2", int'(last_f2), e_l2);
  endtask

  task automatic step(bit ls, bit fs, bit fid, logic [1:0] md, bit we, bit wf, int wv);
    int tot;
    line_stb = ls; field_stb = fs; field_id = fid; mode_sel = md;
    cfg_we = we; cfg_fld = wf; cfg_val = wv[9:0];
    @(posedge clk);
    tot = e_m525 ? 525 : 625;
    if (fs && !fid) e_line = 1;
    else if (ls) e_line = (e_line >= tot) ? 1 : e_line + 1;
    if (fs) e_m525 = md[1];
    if (we) begin if (wf) e_l2 = wv[9:0]; else e_l1 = wv[9:0]; end
    @(negedge clk);
    check_all(fs && !fid);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R3 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 line", int'(line_num), 1);
    chk("R1 last1", int'(last_f1), 22);
    chk("R1 last2", int'(last_f2), 335);
    chk("R1 blank", int'(blank_force), 1);
    // R9 field-1 window into the field-2 blanked range (R8 overlap)
    step(0, 0, 0, 2'b00, 1, 0, 313);
    step(0, 1, 0, 2'b01, 0, 0, 0);
    for (int i = 0; i < 630; i++) step(1, 0, 0, 2'b01, 0, 0, 0);
    // R10 mode request without field strobe has no effect
    step(0, 1, 0, 2'b00, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 2'b10, 0, 0, 0);
    chk("R10 line6 blank", int'(blank_force), 0);
    chk("R10 line6 eligible", int'(vbi_ok), 1);
    // R10 field-2 strobe latches mode, keeps line
    step(0, 1, 1, 2'b10, 0, 0, 0);
    chk("R10 hold line", int'(line_num), 6);
    chk("R10 line6 blank 525", int'(blank_force), 1);
    step(0, 1, 0, 2'b11, 1, 0, 21);
    step(0, 0, 0, 2'b11, 1, 1, 284);
    for (int i = 0; i < 530; i++) step(1, 0, 0, 2'b11, 0, 0, 0);
    // R2 priority over line strobe
    step(1, 1, 0, 2'b11, 0, 0, 0);
    chk("R2 priority", int'(line_num), 1);
    // random mix
    begin
      logic [1:0] md = 2'b11;
      for (int i = 0; i < 4000; i++) begin
        int r = $urandom;
        if (r[20:16] == 0) md = r[12:11];
        step(r[2:0] != 0, r[9:3] == 0, r[10], md, r[25:21] == 0, r[26],
             $urandom_range(0, 640));
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule